// File: doc/BRIEF.md
# Maintenance and Doorbell Window Translator

This block sits on a local memory-mapped bus and watches two address windows. The first is a 4 MB maintenance window. The second is a 4 KB doorbell window, which software normally places directly above the first. A local access that lands in the maintenance window becomes one outbound maintenance request for the serial interconnect. The request carries the access kind, the destination ID, the hop count, a 24-bit remote configuration offset, big-endian byte lanes and the write data. For a read, the local bus is held with a wait signal until the remote response arrives. The response data is then handed back to the local bus.

Each window has three configuration registers, loaded through a simple write port:
- a base register, matched on the address bits above the window size;
- an attribute register, whose bit 31 enables the window;
- a translation register.

The translation register packs the destination ID in bits 31:22 and the hop count in bits 19:12. Bits 11:0 hold the word-aligned remote offset shifted right by 9. A store into the doorbell window becomes a doorbell request, which carries a 16-bit info field taken from the store data. An access to a disabled window, or a read of the doorbell window, is dropped. Such an access sets a sticky error flag, as does an error response.

Top module: `mdbw_xlate`

## Requirements
- R1: After reset, rq_valid is low, lb_wait is low and err_flag is low.
- R2: A maintenance-window read issues one request with rq_kind 2'b00 (read). rq_dest is translation bits 31:22 and rq_hop is translation bits 19:12.
- R3: The remote offset on rq_offset is (translation bits 11:0 shifted left by 9) ORed with the address offset inside the 4 MB window, zero-extended to 24 bits.
- R4: rq_lanes uses bit 3 for data bits 31:24, which is the lowest byte address (big-endian).
  - Size code 2'b00 (1 byte) gives 4'b1000 shifted right by address bits 1:0.
  - Size code 2'b01 (2 bytes) gives 4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1.
  - Size code 2'b10 (4 bytes) gives 4'b1111.
- R5: A maintenance-window write issues one request with rq_kind 2'b01 (write) and rq_wdata equal to lb_wdata.
- R6: During a read, lb_wait stays high until the response is taken. In the cycle lb_wait goes low, lb_rdata holds rsp_data.
- R7: A response with rsp_err high sets err_flag. err_flag then stays high until reset.
- R8: A store into the doorbell window issues one request with rq_kind 2'b10 (doorbell). rq_dest is the doorbell translation bits 31:22, with rq_hop and rq_offset zero. rq_wdata[15:0] is lb_wdata[31:16] when address bit 1 is 0 and lb_wdata[15:0] when it is 1. The access completes without waiting for a response.
- R9: An access to a window whose enable bit (attribute bit 31) is clear issues no request and sets err_flag. lb_wait goes low one cycle later.
- R10: An access outside both windows issues no request, keeps lb_wait low and leaves err_flag unchanged.
- R11: A read of the doorbell window issues no request and sets err_flag.
- R12: While rq_valid is high and rq_ready is low, rq_valid stays high and all request fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_win | input | 1 | Window select: 0 maintenance, 1 doorbell |
| cfg_sel | input | 2 | Register select: 0 base, 1 attribute, 2 translation |
| cfg_wdata | input | 32 | Configuration write data |
| lb_valid | input | 1 | Local access present, held until lb_wait is low |
| lb_write | input | 1 | Local access is a write |
| lb_addr | input | AW | Local byte address |
| lb_size | input | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| lb_wdata | input | 32 | Local write data, lane-aligned |
| lb_wait | output | 1 | Local access not yet complete |
| lb_rdata | output | 32 | Read data returned to the local bus |
| err_flag | output | 1 | Sticky error flag |
| rq_valid | output | 1 | Outbound request valid |
| rq_ready | input | 1 | Outbound request accepted |
| rq_kind | output | 2 | Request kind: 0 read, 1 write, 2 doorbell |
| rq_dest | output | 10 | Destination ID |
| rq_hop | output | 8 | Hop count |
| rq_offset | output | 24 | Remote configuration offset |
| rq_lanes | output | 4 | Byte lanes, bit 3 is the lowest address |
| rq_wdata | output | 32 | Write data or doorbell info |
| rsp_valid | input | 1 | Read response present |
| rsp_err | input | 1 | Read response carries an error |
| rsp_data | input | 32 | Read response data |

## Verification
Most internal faults show up at the request port in the very cycle rq_valid rises:
- a wrong window decode or translation-register field shows as a wrong destination, hop count or offset;
- a wrong lane map shows as a wrong rq_lanes pattern;
- a lost doorbell half-word selection shows as the wrong info value.

Faults in the control state show on the local side instead. A state machine that skips or repeats a state shows as lb_wait falling too early, which returns stale lb_rdata, or as lb_wait never falling. A drop path that still issues a request shows as rq_valid rising one cycle after a disabled or illegal access. A cleared error flag shows on err_flag one access later.

// File: rtl/mdbw_pkg.sv
package mdbw_pkg;
  localparam int OFF_W   = 24;
  localparam int DEST_W  = 10;
  localparam int HOP_W   = 8;
  localparam int XLO_W   = 12;
  localparam int XSHIFT  = 9;

  typedef enum logic [1:0] {RK_RD = 2'd0, RK_WR = 2'd1, RK_DB = 2'd2} rq_kind_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_RESP, ST_DONE} xl_state_t;

  function automatic logic [OFF_W-1:0] f_remote_off(input logic [XLO_W-1:0] xlo,
                                                    input logic [OFF_W-1:0] woff);
    logic [OFF_W-1:0] hi;
    hi = OFF_W'({xlo, {XSHIFT{1'b0}}});
    return hi | woff;
  endfunction

  function automatic logic [3:0] f_lanes(input logic [1:0] sz, input logic [1:0] a);
    case (sz)
      2'd0:    return 4'b1000 >> a;
      2'd1:    return a[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [15:0] f_db_info(input logic a1, input logic [31:0] wd);
    return a1 ? wd[15:0] : wd[31:16];
  endfunction
endpackage

// File: rtl/mdbw_win_reg.sv
module mdbw_win_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [31:0]   wdata,
  output logic [AW-1:0] base,
  output logic          en,
  output logic [31:0]   xlat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      en   <= 1'b0;
      xlat <= '0;
    end else if (we) begin
      case (sel)
        2'd0:    base <= AW'(wdata);
        2'd1:    en   <= wdata[31];
        2'd2:    xlat <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mdbw_decode.sv
module mdbw_decode #(
  parameter int AW      = 32,
  parameter int MWIN_LG = 22,
  parameter int DWIN_LG = 12
) (
  input  logic [AW-1:0]      addr,
  input  logic [AW-1:0]      base_m,
  input  logic [AW-1:0]      base_d,
  output logic               hit_m,
  output logic               hit_d,
  output logic [MWIN_LG-1:0] win_off
);
  assign hit_m   = (addr[AW-1:MWIN_LG] == base_m[AW-1:MWIN_LG]);
  assign hit_d   = (addr[AW-1:DWIN_LG] == base_d[AW-1:DWIN_LG]);
  assign win_off = addr[MWIN_LG-1:0];
endmodule

// File: rtl/mdbw_xlate.sv
module mdbw_xlate
  import mdbw_pkg::*;
#(
  parameter int AW      = 32,
  parameter int MWIN_LG = 22,
  parameter int DWIN_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_win,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              lb_valid,
  input  logic              lb_write,
  input  logic [AW-1:0]     lb_addr,
  input  logic [1:0]        lb_size,
  input  logic [31:0]       lb_wdata,
  output logic              lb_wait,
  output logic [31:0]       lb_rdata,
  output logic              err_flag,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [1:0]        rq_kind,
  output logic [DEST_W-1:0] rq_dest,
  output logic [HOP_W-1:0]  rq_hop,
  output logic [OFF_W-1:0]  rq_offset,
  output logic [3:0]        rq_lanes,
  output logic [31:0]       rq_wdata,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  input  logic [31:0]       rsp_data
);
  localparam int NWIN = 2;
  localparam int DEST_LSB = 32 - DEST_W;

  logic [AW-1:0] base_w [NWIN];
  logic          en_w   [NWIN];
  logic [31:0]   xlat_w [NWIN];

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    mdbw_win_reg #(.AW(AW)) u_reg (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we && (cfg_win == 1'(w))), .sel(cfg_sel), .wdata(cfg_wdata),
      .base(base_w[w]), .en(en_w[w]), .xlat(xlat_w[w])
    );
  end

  logic               hit_m, hit_d;
  logic [MWIN_LG-1:0] win_off;

  mdbw_decode #(.AW(AW), .MWIN_LG(MWIN_LG), .DWIN_LG(DWIN_LG)) u_dec (
    .addr(lb_addr), .base_m(base_w[0]), .base_d(base_w[1]),
    .hit_m(hit_m), .hit_d(hit_d), .win_off(win_off)
  );

  xl_state_t   state;
  rq_kind_t    kind_q;
  logic        hit_any, is_db, win_en;
  logic [31:0] xl;
  logic        acc_start, acc_drop, acc_go, rq_fire, rsp_take;

  assign hit_any   = hit_m || hit_d;
  assign is_db     = !hit_m && hit_d;
  assign win_en    = hit_m ? en_w[0] : en_w[1];
  assign xl        = hit_m ? xlat_w[0] : xlat_w[1];
  assign acc_start = (state == ST_IDLE) && lb_valid && hit_any;
  assign acc_drop  = acc_start && (!win_en || (is_db && !lb_write));
  assign acc_go    = acc_start && !acc_drop;
  assign rq_valid  = (state == ST_SEND);
  assign rq_fire   = rq_valid && rq_ready;
  assign rsp_take  = (state == ST_RESP) && rsp_valid;
  assign rq_kind   = kind_q;
  assign lb_wait   = lb_valid && (acc_start || state == ST_SEND || state == ST_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind_q    <= RK_RD;
      rq_dest   <= '0;
      rq_hop    <= '0;
      rq_offset <= '0;
      rq_lanes  <= '0;
      rq_wdata  <= '0;
      lb_rdata  <= '0;
      err_flag  <= 1'b0;
    end else begin
      if (acc_drop || (rsp_take && rsp_err)) err_flag <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (acc_drop) state <= ST_DONE;
          else if (acc_go) begin
            state   <= ST_SEND;
            rq_dest <= xl[31:DEST_LSB];
            if (is_db) begin
              kind_q    <= RK_DB;
              rq_hop    <= '0;
              rq_offset <= '0;
              rq_lanes  <= lb_addr[1] ? 4'b0011 : 4'b1100;
              rq_wdata  <= {16'h0, f_db_info(lb_addr[1], lb_wdata)};
            end else begin
              kind_q    <= lb_write ? RK_WR : RK_RD;
              rq_hop    <= xl[19:12];
              rq_offset <= f_remote_off(xl[XLO_W-1:0], OFF_W'(win_off));
              rq_lanes  <= f_lanes(lb_size, lb_addr[1:0]);
              rq_wdata  <= lb_wdata;
            end
          end
        end
        ST_SEND: if (rq_ready) state <= (kind_q == RK_RD) ? ST_RESP : ST_DONE;
        ST_RESP: if (rsp_valid) begin
          state    <= ST_DONE;
          lb_rdata <= rsp_data;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_offset) && $stable(rq_dest) && $stable(rq_wdata) && $stable(rq_lanes)) else $error("AST_REQ_HOLD"); // R12
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag) else $error("AST_ERR_STICKY"); // R7
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_drop |=> !rq_valid && err_flag) else $error("AST_DROP_SILENT"); // R9
  AST_LANES_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid |-> ($countones(rq_lanes) == 1 || $countones(rq_lanes) == 2 || $countones(rq_lanes) == 4)) else $error("AST_LANES_SHAPE"); // R4
  AST_RESP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RESP) |-> (rq_kind == 2'd0)) else $error("AST_RESP_ONLY_READ"); // R6
  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && lb_valid && !hit_any) |=> !rq_valid && $stable(err_flag)) else $error("AST_MISS_IGNORED"); // R10
endmodule

// File: tb/mdbw_xlate_tb_top.sv
`timescale 1ns/1ps
module mdbw_xlate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_win = 0; logic [1:0] cfg_sel = 0; logic [31:0] cfg_wdata = 0;
  logic lb_valid = 0, lb_write = 0; logic [31:0] lb_addr = 0; logic [1:0] lb_size = 0;
  logic [31:0] lb_wdata = 0;
  logic lb_wait, err_flag, rq_valid; logic [31:0] lb_rdata;
  logic rq_ready = 0; logic [1:0] rq_kind; logic [9:0] rq_dest; logic [7:0] rq_hop;
  logic [23:0] rq_offset; logic [3:0] rq_lanes; logic [31:0] rq_wdata;
  logic rsp_valid = 0, rsp_err = 0; logic [31:0] rsp_data = 0;
  int n_tests = 0, n_fail = 0;

  localparam logic [31:0] MBASE = 32'h8000_0000, DBASE = 32'h8040_0000;
  localparam logic [31:0] MXL = (32'h2A << 22) | (32'h3 << 12), DXL = 32'h155 << 22;

  always #10 clk = ~clk;

  mdbw_xlate dut_i (.*);

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(bit win, logic [1:0] sel, logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_win = win; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
  endtask

  task automatic setup(bit m_en, logic [31:0] mxl);
    cfg(0, 0, MBASE); cfg(0, 1, {m_en, 31'h0}); cfg(0, 2, mxl);
    cfg(1, 0, DBASE); cfg(1, 1, 32'h8000_0000); cfg(1, 2, DXL);
  endtask

  bit got, stable_ok; int ncyc;
  logic [1:0] c_kind; logic [9:0] c_dest; logic [7:0] c_hop; logic [23:0] c_off;
  logic [3:0] c_lanes; logic [31:0] c_wd, rd;

  task automatic access(bit wr, logic [31:0] a, logic [1:0] sz, logic [31:0] wd,
                        int rdy_dly, logic [31:0] rdat, bit rerr);
    int n = 0; bit seen = 0, sent = 0;
    got = 0; stable_ok = 1; ncyc = 0;
    @(negedge clk);
    lb_valid = 1; lb_write = wr; lb_addr = a; lb_size = sz; lb_wdata = wd; rq_ready = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); ncyc++;
      if (!lb_wait) begin
        rd = lb_rdata; lb_valid = 0; rsp_valid = 0; rq_ready = 0;
        break;
      end
      rsp_valid = 0;
      if (rq_valid && !got) begin
        if (!seen) begin
          seen = 1; c_kind = rq_kind; c_dest = rq_dest; c_hop = rq_hop;
          c_off = rq_offset; c_lanes = rq_lanes; c_wd = rq_wdata;
        end else if ({c_kind, c_dest, c_hop, c_off, c_lanes, c_wd} !==
                     {rq_kind, rq_dest, rq_hop, rq_offset, rq_lanes, rq_wdata})
          stable_ok = 0;
        if (n >= rdy_dly) begin rq_ready = 1; got = 1; end
        else n++;
      end else begin
        rq_ready = 0;
        if (got && !wr && !sent) begin
          rsp_valid = 1; rsp_data = rdat; rsp_err = rerr; sent = 1;
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rq_valid", rq_valid, 0); chk("R1 lb_wait", lb_wait, 0); chk("R1 err_flag", err_flag, 0);
  endtask

  task automatic t_read_word();
    access(0, MBASE + 32'h104, 2, 0, 0, 32'hDEAD_BEEF, 0);
    chk("R2 got", got, 1); chk("R2 kind", c_kind, 0); chk("R2 dest", c_dest, 10'h2A);
    chk("R2 hop", c_hop, 3); chk("R3 off", c_off, 24'h104); chk("R4 lanes word", c_lanes, 4'hF);
    chk("R6 rdata", rd, 32'hDEAD_BEEF); chk("R7 no err", err_flag, 0);
  endtask

  task automatic t_write_merge();
    cfg(0, 2, MXL | (32'h012000 >> 9));
    access(1, MBASE + 32'h10, 2, 32'h1122_3344, 0, 0, 0);
    chk("R5 kind", c_kind, 1); chk("R5 wdata", c_wd, 32'h1122_3344);
    chk("R3 merged off", c_off, 24'h012010);
    cfg(0, 2, MXL);
    access(0, MBASE + 32'h3F_FFFC, 2, 0, 0, 32'h5, 0);
    chk("R3 top of window", c_off, 24'h3F_FFFC);
  endtask

  task automatic t_lanes();
    access(1, MBASE + 1, 0, 32'h00AA_0000, 0, 0, 0); chk("R4 byte off1", c_lanes, 4'b0100);
    access(1, MBASE + 3, 0, 32'h0000_00AA, 0, 0, 0); chk("R4 byte off3", c_lanes, 4'b0001);
    access(0, MBASE + 2, 1, 0, 0, 32'h0000_1234, 0); chk("R4 half off2", c_lanes, 4'b0011);
    chk("R6 half rdata", rd, 32'h0000_1234);
  endtask

  task automatic t_hold();
    access(0, MBASE + 32'h40, 2, 0, 3, 32'hCAFE_0001, 0);
    chk("R12 stable", stable_ok, 1); chk("R12 offset", c_off, 24'h40);
    chk("R6 rdata after stall", rd, 32'hCAFE_0001);
  endtask

  task automatic t_doorbell();
    access(1, DBASE, 1, 32'hABCD_0000, 0, 0, 0);
    chk("R8 kind", c_kind, 2); chk("R8 dest", c_dest, 10'h155); chk("R8 hop", c_hop, 0);
    chk("R8 off", c_off, 0); chk("R8 info hi", c_wd[15:0], 16'hABCD);
    access(1, DBASE + 2, 1, 32'h0000_5A5A, 0, 0, 0);
    chk("R8 info lo", c_wd[15:0], 16'h5A5A); chk("R8 err clear", err_flag, 0);
  endtask

  task automatic t_miss();
    access(0, 32'h1000_0000, 2, 0, 0, 0, 0);
    chk("R10 no req", got, 0); chk("R10 fast", ncyc, 1); chk("R10 err", err_flag, 0);
  endtask

  task automatic t_disabled();
    do_reset(); setup(0, MXL);
    access(1, MBASE + 8, 2, 32'h1, 0, 0, 0);
    chk("R9 no req", got, 0); chk("R9 one cycle", ncyc, 1); chk("R9 err", err_flag, 1);
  endtask

  task automatic t_db_read();
    do_reset(); setup(1, MXL);
    chk("R1 err after reset", err_flag, 0);
    access(0, DBASE, 1, 0, 0, 0, 0);
    chk("R11 no req", got, 0); chk("R11 err", err_flag, 1);
  endtask

  task automatic t_rsp_err();
    do_reset(); setup(1, MXL);
    access(0, MBASE + 4, 2, 0, 0, 32'h0, 1);
    chk("R7 err set", err_flag, 1);
    access(0, MBASE + 8, 2, 0, 0, 32'h77, 0);
    chk("R7 sticky", err_flag, 1); chk("R6 rdata", rd, 32'h77);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    setup(1, MXL);
    t_read_word(); t_write_merge(); t_lanes(); t_hold(); t_doorbell(); t_miss();
    t_disabled(); t_db_read(); t_rsp_err();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule